// File: doc/BRIEF.md
# Windowed Single-Bin DFT Correlator

This block measures the complex response of a sampled signal at one excitation frequency. After a start pulse it takes 1024 valid ADC samples, converts each from offset binary to signed form, scales it by a symmetric bell-shaped window weight chosen by the sample's position in the block, and multiplies the weighted sample by a cosine reference and a sine reference supplied with it. The two product streams are summed in two wide accumulators. When the 1024th sample has been taken, both sums are scaled down by a fixed right shift to 16-bit signed words and published together with a done flag.

One start pulse and 1024 samples give one real and one imaginary word for a single frequency point of a sweep. Software reads the two words and derives magnitude as sqrt(R² + I²) and phase as arctan(I/R). Samples that arrive outside a measurement are dropped, so the sample source may run freely between points.

A small controller with three states sequences the block: `ST_IDLE` (after reset, nothing measured yet), `ST_ACCUM` (taking samples) and `ST_HOLD` (result published, waiting). The transitions are: START, from any state to `ST_ACCUM` on a start pulse; FINISH, from `ST_ACCUM` to `ST_HOLD` on the 1024th accepted sample. Every other case keeps the current state.

Top module: `dft_bin_correlator`

## Requirements
- R1: While reset is applied and until the first completed measurement, `done_o` is 0 and `real_o` and `imag_o` are 0.
- R2: The 12-bit sample `s` is taken as offset binary centred at 2048: the signed value used is `s - 2048` (so 2048 contributes nothing, 0 gives -2048, 4095 gives +2047).
- R3: The n-th accepted sample of a measurement (n counted from 0 to 1023 since the start pulse) is weighted by w(n) = min(4095, (n·(1024−n)) >> 6), so w(0) = 0 and w(512) = 4095.
- R4: At completion, `real_o` is bits 15..0 of (Σ (s−2048)·w(n)·c) >>> 29 and `imag_o` is bits 15..0 of (Σ (s−2048)·w(n)·q) >>> 29, with c and q the signed 12-bit cosine and sine inputs of the same cycle; the 47-bit sums never overflow for any input.
- R5: `done_o` rises on the clock edge that accepts the 1024th sample, and `real_o` and `imag_o` take their new values on that same edge; `done_o` then stays 1 until the next start pulse.
- R6: A start pulse clears both sums and the sample count and drops `done_o` on the next edge; `real_o` and `imag_o` keep their previous values until the next measurement completes.
- R7: A sample is taken only when `sample_valid_i` is 1 during a measurement; samples before the first start pulse and after completion (until the next start pulse) change neither the outputs nor the next result.
- R8: A sample presented in the same cycle as the start pulse is discarded; the first sample counted is the first valid one after the pulse.
- R9: A start pulse during a measurement abandons it: the result then reflects only the 1024 samples accepted after the latest pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle pulse that begins a measurement |
| sample_valid_i | input | 1 | Qualifies the sample and reference inputs |
| sample_i | input | 12 | ADC sample, offset binary |
| cos_i | input | 12 | Cosine reference, signed two's complement |
| sin_i | input | 12 | Sine reference, signed two's complement |
| real_o | output | 16 | Real result word, signed |
| imag_o | output | 16 | Imaginary result word, signed |
| done_o | output | 1 | High from completion until the next start pulse |

## Verification
A wrong sample count or window index inside the block is invisible until completion: it shows up 1024 accepted samples later as a wrong real or imaginary word, or as `done_o` rising one or more cycles early or late, so every run compares both words and the exact cycle of the done edge. A sum that was not cleared, or that kept counting in the hold state, appears only in the next result, so runs are chained with stray samples between them and impulse runs that isolate single window positions. A controller stuck in the wrong state shows at once as `done_o` failing to drop one cycle after a start pulse.

// File: rtl/dft_pkg.sv
package dft_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ACCUM = 2'd1,
        ST_HOLD  = 2'd2
    } dft_state_e;

endpackage

// File: rtl/dft_window_gen.sv
// Bell-shaped window weight computed from the sample position.
// w(n) = min(2^WIN_W - 1, (n * (N - n)) >> (2*N_LOG2 - 2 - WIN_W))
module dft_window_gen #(
    parameter int N_LOG2 = 10,
    parameter int WIN_W  = 12
) (
    input  logic [N_LOG2-1:0] idx_i,
    output logic [WIN_W-1:0]  coef_o
);
    localparam int OP_W = N_LOG2 + 1;
    localparam int PR_W = 2 * OP_W;
    localparam int WSH  = 2 * N_LOG2 - 2 - WIN_W;
    localparam logic [OP_W-1:0] N_VAL = OP_W'(1 << N_LOG2);
    localparam logic [PR_W-1:0] W_MAX = PR_W'((1 << WIN_W) - 1);

    logic [OP_W-1:0] pos;
    logic [OP_W-1:0] rem;
    logic [PR_W-1:0] para;
    logic [PR_W-1:0] scaled;

    always_comb begin
        pos    = {1'b0, idx_i};
        rem    = N_VAL - pos;
        para   = PR_W'(pos) * PR_W'(rem);
        scaled = para >> WSH;
        if (scaled > W_MAX) begin
            coef_o = W_MAX[WIN_W-1:0];
        end else begin
            coef_o = scaled[WIN_W-1:0];
        end
    end
endmodule

// File: rtl/dft_mac_lane.sv
// One multiply-accumulate lane: weighted sample times reference.
module dft_mac_lane #(
    parameter int WX_W  = 25,
    parameter int REF_W = 12,
    parameter int ACC_W = 47
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr_i,
    input  logic                    en_i,
    input  logic signed [WX_W-1:0]  wx_i,
    input  logic signed [REF_W-1:0] ref_i,
    output logic signed [ACC_W-1:0] acc_o,
    output logic signed [ACC_W-1:0] acc_next_o
);
    localparam int PROD_W = WX_W + REF_W;

    logic signed [PROD_W-1:0] prod;

    always_comb begin
        prod       = PROD_W'(wx_i) * PROD_W'(ref_i);
        acc_next_o = acc_o + {{(ACC_W - PROD_W){prod[PROD_W-1]}}, prod};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_o <= '0;
        end else if (clr_i) begin
            acc_o <= '0;
        end else if (en_i) begin
            acc_o <= acc_next_o;
        end
    end
endmodule

// File: rtl/dft_seq_ctrl.sv
// Measurement sequencer: state register, next-state logic, sample counter.
module dft_seq_ctrl
    import dft_pkg::*;
#(
    parameter int N_LOG2 = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              sample_valid_i,
    output dft_state_e        state_o,
    output logic              clr_o,
    output logic              acc_en_o,
    output logic              last_o,
    output logic [N_LOG2-1:0] idx_o
);
    localparam logic [N_LOG2-1:0] LAST_IDX = '1;

    dft_state_e state_q;
    dft_state_e state_d;
    logic [N_LOG2-1:0] cnt_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs and transitions
    always_comb begin
        clr_o    = start_i;
        acc_en_o = 1'b0;
        last_o   = 1'b0;
        state_d  = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) state_d = ST_ACCUM;
            end
            ST_ACCUM: begin
                acc_en_o = sample_valid_i && !start_i;
                last_o   = acc_en_o && (cnt_q == LAST_IDX);
                if (start_i)     state_d = ST_ACCUM;
                else if (last_o) state_d = ST_HOLD;
            end
            ST_HOLD: begin
                if (start_i) state_d = ST_ACCUM;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start_i) begin
            cnt_q <= '0;
        end else if (acc_en_o) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign state_o = state_q;
    assign idx_o   = cnt_q;
endmodule

// File: rtl/dft_bin_correlator.sv
module dft_bin_correlator
    import dft_pkg::*;
#(
    parameter int SAMPLE_W = 12,
    parameter int REF_W    = 12,
    parameter int WIN_W    = 12,
    parameter int N_LOG2   = 10,
    parameter int RES_W    = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic                    sample_valid_i,
    input  logic [SAMPLE_W-1:0]     sample_i,
    input  logic signed [REF_W-1:0] cos_i,
    input  logic signed [REF_W-1:0] sin_i,
    output logic signed [RES_W-1:0] real_o,
    output logic signed [RES_W-1:0] imag_o,
    output logic                    done_o
);
    localparam int WX_W   = SAMPLE_W + WIN_W + 1;
    localparam int ACC_W  = WX_W + REF_W + N_LOG2;
    localparam int PEAK_W = (SAMPLE_W - 1) + (REF_W - 1) + WIN_W + N_LOG2;
    localparam int SHIFT  = PEAK_W - (RES_W - 1);

    dft_state_e state;
    logic clr, acc_en, last;
    logic [N_LOG2-1:0] idx;
    logic [WIN_W-1:0]  coef;
    logic signed [SAMPLE_W-1:0] xs;
    logic signed [WX_W-1:0]     wx;
    logic signed [ACC_W-1:0] acc_re, acc_im, nxt_re, nxt_im;
    logic signed [ACC_W-1:0] sh_re, sh_im;

    dft_seq_ctrl #(.N_LOG2(N_LOG2)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .sample_valid_i(sample_valid_i), .state_o(state), .clr_o(clr),
        .acc_en_o(acc_en), .last_o(last), .idx_o(idx)
    );

    dft_window_gen #(.N_LOG2(N_LOG2), .WIN_W(WIN_W)) win_i (
        .idx_i(idx), .coef_o(coef)
    );

    // offset binary to signed: invert the top bit
    always_comb begin
        xs = $signed({~sample_i[SAMPLE_W-1], sample_i[SAMPLE_W-2:0]});
        wx = WX_W'(xs) * $signed({1'b0, coef});
    end

    dft_mac_lane #(.WX_W(WX_W), .REF_W(REF_W), .ACC_W(ACC_W)) lane_re_i (
        .clk(clk), .rst_n(rst_n), .clr_i(clr), .en_i(acc_en),
        .wx_i(wx), .ref_i(cos_i), .acc_o(acc_re), .acc_next_o(nxt_re)
    );

    dft_mac_lane #(.WX_W(WX_W), .REF_W(REF_W), .ACC_W(ACC_W)) lane_im_i (
        .clk(clk), .rst_n(rst_n), .clr_i(clr), .en_i(acc_en),
        .wx_i(wx), .ref_i(sin_i), .acc_o(acc_im), .acc_next_o(nxt_im)
    );

    always_comb begin
        sh_re = nxt_re >>> SHIFT;
        sh_im = nxt_im >>> SHIFT;
    end

    // output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            real_o <= '0;
            imag_o <= '0;
            done_o <= 1'b0;
        end else begin
            if (start_i) begin
                done_o <= 1'b0;
            end else if (last) begin
                done_o <= 1'b1;
            end
            if (last) begin
                real_o <= sh_re[RES_W-1:0];
                imag_o <= sh_im[RES_W-1:0];
            end
        end
    end
endmodule

// File: rtl/dft_bin_correlator_chk.sv
module dft_bin_correlator_chk
    import dft_pkg::*;
#(
    parameter int RES_W = 16,
    parameter int ACC_W = 47
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             sample_valid_i,
    input logic             done_o,
    input logic [RES_W-1:0] real_o,
    input logic [RES_W-1:0] imag_o,
    input dft_state_e       state,
    input logic [ACC_W-1:0] acc_re
);
    assert_idle_no_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !done_o);

    assert_done_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> done_o);

    assert_done_after_sample_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> ($past(sample_valid_i) && !$past(start_i)));

    assert_done_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> !done_o);

    assert_result_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(done_o) |-> ($stable(real_o) && $stable(imag_o)));

    assert_hold_ignores_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && !start_i) |=> $stable(acc_re));
endmodule

bind dft_bin_correlator dft_bin_correlator_chk #(.RES_W(RES_W), .ACC_W(ACC_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .sample_valid_i(sample_valid_i),
    .done_o(done_o), .real_o(real_o), .imag_o(imag_o), .state(state), .acc_re(acc_re)
);

// File: tb/dft_bin_correlator_tb_top.sv
module dft_bin_correlator_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic sample_valid_i = 1'b0;
    logic [11:0] sample_i = 12'd2048;
    logic [11:0] cos_i = '0;
    logic [11:0] sin_i = '0;
    logic [15:0] real_o, imag_o;
    logic done_o;

    int n_tests = 0;
    int n_fail = 0;
    bit finished = 0;

    longint m_re, m_im;
    int m_n = 0;
    bit m_act = 0;
    int exp_re = 0, exp_im = 0;

    always #2 clk = ~clk;

    dft_bin_correlator dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .sample_valid_i(sample_valid_i),
        .sample_i(sample_i), .cos_i(cos_i), .sin_i(sin_i),
        .real_o(real_o), .imag_o(imag_o), .done_o(done_o)
    );

    function automatic longint win(int n);
        longint p = (longint'(n) * longint'(1024 - n)) >> 6;
        if (p > 4095) p = 4095;
        return p;
    endfunction

    function automatic int to_res(longint acc);
        longint s = acc >>> 29;
        return int'(shortint'(s[15:0]));
    endfunction

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic check_res(string req);
        check(int'($signed(real_o)) == exp_re, req, "real_o", int'($signed(real_o)), exp_re);
        check(int'($signed(imag_o)) == exp_im, req, "imag_o", int'($signed(imag_o)), exp_im);
    endtask

    task automatic feed(int adc, int c, int s);
        @(negedge clk);
        start_i = 1'b0;
        sample_valid_i = 1'b1;
        sample_i = adc[11:0];
        cos_i = c[11:0];
        sin_i = s[11:0];
        if (m_act && m_n < 1024) begin
            m_re += longint'(adc - 2048) * win(m_n) * longint'(c);
            m_im += longint'(adc - 2048) * win(m_n) * longint'(s);
            m_n++;
            if (m_n == 1024) begin
                exp_re = to_res(m_re);
                exp_im = to_res(m_im);
            end
        end
    endtask

    task automatic idle_cycle();
        @(negedge clk);
        start_i = 1'b0;
        sample_valid_i = 1'b0;
        sample_i = $urandom % 4096;
    endtask

    task automatic pulse_start(bit with_valid);
        @(negedge clk);
        start_i = 1'b1;
        sample_valid_i = with_valid;
        sample_i = 12'd4095;
        cos_i = 12'd2047;
        sin_i = 12'd2047;
        m_re = 0; m_im = 0; m_n = 0; m_act = 1;
    endtask

    function automatic int rnd_ref();
        return int'($urandom % 4096) - 2048;
    endfunction

    // kind 0: random, 1: constant, 2: impulse at position k
    task automatic run_meas(int kind, int adc, int c, int s, int k, bit gaps, string req);
        while (m_n < 1024) begin
            if (gaps && ($urandom % 4 == 0)) idle_cycle();
            if (m_n == 1023) check(done_o == 1'b0, "R5", "done before last sample", done_o, 0);
            case (kind)
                0: feed(int'($urandom % 4096), rnd_ref(), rnd_ref());
                1: feed(adc, c, s);
                default: feed((m_n == k) ? 4095 : 2048, c, s);
            endcase
        end
        idle_cycle();
        check(done_o == 1'b1, "R5", "done after last sample", done_o, 1);
        check_res(req);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        check(done_o == 1'b0 && real_o == 0 && imag_o == 0, "R1", "reset state", done_o, 0);
        rst_n = 1'b1;

        // R7: samples before any start are ignored
        for (int i = 0; i < 20; i++) feed(4095, 2047, 2047);
        idle_cycle();
        check(done_o == 1'b0, "R7", "done before start", done_o, 0);
        check(real_o == 0, "R1", "real before first result", int'($signed(real_o)), 0);

        // R8 + R4: start with a coincident sample, full-scale constant run
        pulse_start(1'b1);
        run_meas(1, 4095, 2047, -2048, 0, 0, "R4");

        // R7: samples after done are ignored
        for (int i = 0; i < 30; i++) feed(int'($urandom % 4096), rnd_ref(), rnd_ref());
        idle_cycle();
        check(done_o == 1'b1, "R7", "done held after stray samples", done_o, 1);
        check_res("R7");

        // R6: start drops done, results held
        pulse_start(1'b0);
        idle_cycle();
        check(done_o == 1'b0, "R6", "done after start", done_o, 0);
        check_res("R6");
        run_meas(1, 0, -1000, 1500, 0, 1, "R2");

        // R2: mid-scale sample contributes nothing
        pulse_start(1'b0);
        run_meas(1, 2048, 2047, -2048, 0, 1, "R2");
        check(real_o == 0 && imag_o == 0, "R2", "mid-scale result", int'($signed(real_o)), 0);

        // R3: impulses at chosen window positions
        pulse_start(1'b0);
        run_meas(2, 0, 2047, -2047, 512, 0, "R3");
        pulse_start(1'b0);
        run_meas(2, 0, 2047, 2047, 0, 1, "R3");
        check(real_o == 0, "R3", "zero weight at index 0", int'($signed(real_o)), 0);
        pulse_start(1'b0);
        run_meas(2, 0, -2048, 2047, 1023, 0, "R3");
        pulse_start(1'b0);
        run_meas(2, 0, 2047, 2047, 100, 0, "R3");

        // R9: restart in the middle of a measurement
        pulse_start(1'b0);
        for (int i = 0; i < 300; i++) feed(int'($urandom % 4096), rnd_ref(), rnd_ref());
        pulse_start(1'b0);
        run_meas(0, 0, 0, 0, 0, 1, "R9");

        // R4: random runs
        for (int r = 0; r < 4; r++) begin
            pulse_start(1'b0);
            run_meas(0, 0, 0, 0, 0, 1, "R4");
        end

        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule